// File: doc/BRIEF.md
# Button Sequence Record/Playback Controller

This block captures a run of 12-bit game-pad frames into an on-chip store and plays them back later, one stored frame per frame latch. A frame receiver upstream supplies each decoded button word with a one-cycle valid strobe. A latch-edge strobe paces playback. Three user buttons (record, stop, play) choose the mode. Button bits are active low, so an all-ones word means that no button is pressed.

The controller has three modes: idle, recording and replaying. A recording runs until the user presses stop or until the store is full (300 frames, about five seconds at a 60 Hz frame rate). The number of frames captured is kept as the end mark for playback. During a replay the display word comes from the store, and live pad data is ignored. A done pulse marks each return to idle. The three buttons are level inputs and only their rising edges act, so a held button starts a mode once and cannot restart it.

Top module: `seq_recorder`

## Requirements
- R1: After reset, mode is 2'b00 (idle), disp_word is 12'hFFF and done is 0.
- R2: In idle mode disp_word is 12'hFFF whatever frame_word carries, and a stop edge leaves the mode at idle with no done pulse.
- R3: A rising edge on rec_btn in idle sets mode to 2'b01 (recording) after the next clock edge. While recording, disp_word equals the live frame_word.
- R4: While recording, each cycle with frame_valid high stores frame_word at the next store address, starting from address 0 for every new recording.
- R5: A rising edge on stop_btn while recording returns the mode to idle and raises done for exactly one cycle. A frame that is valid in the same cycle as the stop edge is still stored.
- R6: When the 300th frame is stored, recording ends by itself: the mode becomes idle and done pulses.
- R7: A rising edge on play_btn in idle, when a recording exists, sets mode to 2'b10 (replaying) with disp_word showing stored frame 0. Each cycle with latch_rise high advances to the next stored frame.
- R8: Replay ends on the latch_rise that would advance the address to the number of frames recorded: the mode becomes idle and done pulses for one cycle.
- R9: While replaying, frame_valid, frame_word and rec_btn have no effect: disp_word keeps the stored frame until the next latch_rise.
- R10: Holding play_btn high after a replay has ended does not start a new replay.
- R11: A play edge when nothing has been recorded pulses done for one cycle, and the mode stays idle.
- R12: A new recording replaces the previous end mark, so a replay after a shorter recording ends after the shorter length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| frame_valid | input | 1 | One-cycle strobe: frame_word holds a complete frame |
| frame_word | input | 12 | Decoded button word, active low |
| latch_rise | input | 1 | One-cycle strobe at each frame latch rising edge |
| rec_btn | input | 1 | Record button level |
| stop_btn | input | 1 | Stop button level |
| play_btn | input | 1 | Play button level |
| disp_word | output | 12 | Word to display: all ones, the live frame, or the stored frame |
| mode | output | 2 | 00 idle, 01 recording, 10 replaying |
| done | output | 1 | One-cycle pulse on each return to idle |

## Verification
Two functions can act in the same clock cycle: storing a frame and ending a recording, either by a stop edge or by reaching the capacity. The bench raises frame_valid in the same cycle as a stop edge, and on the 300th frame in the capacity test. It then judges the outcome through a later replay. The stored frame must appear at the last address, and the replay must end exactly one latch after it, which proves that the write and the end mark both took effect before the mode returned to idle.

// File: rtl/seqrec_pkg.sv
package seqrec_pkg;
    typedef enum logic [1:0] {
        MODE_IDLE = 2'b00,
        MODE_REC  = 2'b01,
        MODE_PLAY = 2'b10
    } mode_e;
endpackage

// File: rtl/seqrec_edge.sv
module seqrec_edge #(
    parameter int N = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] lvl,
    output logic [N-1:0] rise
);
    logic [N-1:0] prev_d, prev_q;

    for (genvar i = 0; i < N; i++) begin : g_bit
        assign rise[i] = lvl[i] & ~prev_q[i];
    end

    always_comb begin
        prev_d = lvl;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) prev_q <= '0;
        else        prev_q <= prev_d;
    end
endmodule

// File: rtl/seqrec_store.sv
module seqrec_store #(
    parameter int W     = 12,
    parameter int DEPTH = 300,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          wr_en,
    input  logic [AW-1:0] wr_addr,
    input  logic [W-1:0]  wr_data,
    input  logic [AW-1:0] rd_addr,
    output logic [W-1:0]  rd_data
);
    logic [W-1:0] cell_q [DEPTH];

    always_ff @(posedge clk) begin
        if (wr_en && (32'(wr_addr) < DEPTH)) cell_q[wr_addr] <= wr_data;
    end

    always_comb begin
        if (32'(rd_addr) < DEPTH) rd_data = cell_q[rd_addr];
        else                      rd_data = '1;
    end
endmodule

// File: rtl/seqrec_ctrl.sv
module seqrec_ctrl
    import seqrec_pkg::*;
#(
    parameter int W     = 12,
    parameter int DEPTH = 300,
    parameter int AW    = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rec_press,
    input  logic          stop_press,
    input  logic          play_press,
    input  logic          frame_valid,
    input  logic [W-1:0]  frame_word,
    input  logic          latch_rise,
    output logic          wr_en,
    output logic [AW-1:0] wr_addr,
    output logic [W-1:0]  wr_data,
    output logic [AW-1:0] rd_addr,
    output mode_e         mode,
    output logic          done
);
    localparam logic [AW-1:0] CAP = AW'(DEPTH);

    typedef struct packed {
        mode_e         mode;
        logic [AW-1:0] rec_addr;
        logic [AW-1:0] play_addr;
        logic [AW-1:0] fin;
        logic          done;
    } ctrl_t;

    ctrl_t s_d, s_q;
    logic [AW-1:0] rec_nxt, play_nxt;

    always_comb begin
        s_d      = s_q;
        s_d.done = 1'b0;
        wr_en    = 1'b0;
        rec_nxt  = s_q.rec_addr + 1'b1;
        play_nxt = s_q.play_addr + 1'b1;
        unique case (s_q.mode)
            MODE_IDLE: begin
                s_d.play_addr = '0;
                if (rec_press) begin
                    s_d.mode     = MODE_REC;
                    s_d.rec_addr = '0;
                    s_d.fin      = '0;
                end else if (play_press) begin
                    if (s_q.fin == '0) s_d.done = 1'b1;
                    else               s_d.mode = MODE_PLAY;
                end
            end
            MODE_REC: begin
                if (frame_valid) begin
                    wr_en        = 1'b1;
                    s_d.rec_addr = rec_nxt;
                    s_d.fin      = rec_nxt;
                end
                if (stop_press || (frame_valid && rec_nxt == CAP)) begin
                    s_d.mode = MODE_IDLE;
                    s_d.done = 1'b1;
                end
            end
            MODE_PLAY: begin
                if (latch_rise) begin
                    if (play_nxt == s_q.fin) begin
                        s_d.mode      = MODE_IDLE;
                        s_d.done      = 1'b1;
                        s_d.play_addr = '0;
                    end else begin
                        s_d.play_addr = play_nxt;
                    end
                end
            end
            default: s_d.mode = MODE_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.mode      <= MODE_IDLE;
            s_q.rec_addr  <= '0;
            s_q.play_addr <= '0;
            s_q.fin       <= '0;
            s_q.done      <= 1'b0;
        end else begin
            s_q <= s_d;
        end
    end

    assign wr_addr = s_q.rec_addr;
    assign wr_data = frame_word;
    assign rd_addr = s_q.play_addr;
    assign mode    = s_q.mode;
    assign done    = s_q.done;
endmodule

// File: rtl/seq_recorder.sv
module seq_recorder
    import seqrec_pkg::*;
#(
    parameter int W     = 12,
    parameter int DEPTH = 300
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         frame_valid,
    input  logic [W-1:0] frame_word,
    input  logic         latch_rise,
    input  logic         rec_btn,
    input  logic         stop_btn,
    input  logic         play_btn,
    output logic [W-1:0] disp_word,
    output logic [1:0]   mode,
    output logic         done
);
    localparam int AW = $clog2(DEPTH + 1);

    logic [2:0]    press;
    logic          wr_en;
    logic [AW-1:0] wr_addr, rd_addr;
    logic [W-1:0]  wr_data, rd_data;
    mode_e         mode_s;

    seqrec_edge #(.N(3)) u_edge (
        .clk  (clk),
        .rst_n(rst_n),
        .lvl  ({play_btn, stop_btn, rec_btn}),
        .rise (press)
    );

    seqrec_ctrl #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .rec_press  (press[0]),
        .stop_press (press[1]),
        .play_press (press[2]),
        .frame_valid(frame_valid),
        .frame_word (frame_word),
        .latch_rise (latch_rise),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .rd_addr    (rd_addr),
        .mode       (mode_s),
        .done       (done)
    );

    seqrec_store #(.W(W), .DEPTH(DEPTH), .AW(AW)) u_store (
        .clk    (clk),
        .wr_en  (wr_en),
        .wr_addr(wr_addr),
        .wr_data(wr_data),
        .rd_addr(rd_addr),
        .rd_data(rd_data)
    );

    always_comb begin
        unique case (mode_s)
            MODE_REC:  disp_word = frame_word;
            MODE_PLAY: disp_word = rd_data;
            default:   disp_word = '1;
        endcase
    end

    assign mode = mode_s;
endmodule

// File: rtl/seqrec_chk.sv
module seqrec_chk #(
    parameter int W = 12
) (
    input logic         clk,
    input logic         rst_n,
    input logic         rec_btn,
    input logic         latch_rise,
    input logic [W-1:0] disp_word,
    input logic [1:0]   mode,
    input logic         done
);
    // R5
    done_in_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mode == 2'b00);

    // R8
    done_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R3
    rec_enter_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00 && rec_btn && !$past(rec_btn)) |=> mode == 2'b01);

    // R9
    play_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b10 && $past(mode) == 2'b10 && !$past(latch_rise))
        |-> $stable(disp_word));

    // R2
    idle_blank_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'b00) |-> disp_word == '1);

    // R7
    no_rec_to_play_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(mode) == 2'b01) |-> mode != 2'b10);

    // R1
    legal_mode_chk: assert property (@(posedge clk) disable iff (!rst_n)
        mode != 2'b11);
endmodule

bind seq_recorder seqrec_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rec_btn   (rec_btn),
    .latch_rise(latch_rise),
    .disp_word (disp_word),
    .mode      (mode),
    .done      (done)
);

// File: tb/sim_seq_recorder.sv
module sim_seq_recorder;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_valid = 1'b0;
    logic [11:0] frame_word = 12'hFFF;
    logic        latch_rise = 1'b0;
    logic        rec_btn = 1'b0, stop_btn = 1'b0, play_btn = 1'b0;
    logic [11:0] disp_word;
    logic [1:0]  mode;
    logic        done;

    int n_run = 0;
    int n_fail = 0;

    seq_recorder u0 (
        .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid),
        .frame_word(frame_word), .latch_rise(latch_rise),
        .rec_btn(rec_btn), .stop_btn(stop_btn), .play_btn(play_btn),
        .disp_word(disp_word), .mode(mode), .done(done)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        logic        rec, stop, play, fv, lat;
        logic [11:0] word;
        logic [1:0]  emode;
        logic [11:0] edisp;
        logic        edone;
    } vec_t;

    localparam int NV = 17;
    localparam vec_t TBL [NV] = '{
        '{0,0,0,0,0,12'h123, 2'd0,12'hFFF,1'b0}, // R2 idle blank
        '{0,1,0,0,0,12'h000, 2'd0,12'hFFF,1'b0}, // R2 stop ignored
        '{1,0,0,0,0,12'hAAA, 2'd1,12'hAAA,1'b0}, // R3 enter record
        '{1,0,0,1,0,12'h111, 2'd1,12'h111,1'b0}, // R4 addr0
        '{0,0,0,1,0,12'h222, 2'd1,12'h222,1'b0}, // R4 addr1
        '{0,0,0,0,0,12'h7FF, 2'd1,12'h7FF,1'b0}, // R3 live
        '{0,0,0,1,0,12'h333, 2'd1,12'h333,1'b0}, // R4 addr2
        '{0,1,0,1,0,12'h444, 2'd0,12'hFFF,1'b1}, // R5 stop with frame
        '{0,0,0,0,0,12'h000, 2'd0,12'hFFF,1'b0}, // R5 pulse ends
        '{0,0,1,0,0,12'h000, 2'd2,12'h111,1'b0}, // R7 enter play
        '{0,0,1,1,0,12'h555, 2'd2,12'h111,1'b0}, // R9 live ignored
        '{0,0,0,0,1,12'h000, 2'd2,12'h222,1'b0}, // R7 advance
        '{1,0,0,1,0,12'h666, 2'd2,12'h222,1'b0}, // R9 rec ignored
        '{0,0,0,0,1,12'h000, 2'd2,12'h333,1'b0}, // R7
        '{0,0,0,0,1,12'h000, 2'd2,12'h444,1'b0}, // R5 frame kept
        '{0,0,0,0,1,12'h000, 2'd0,12'hFFF,1'b1}, // R8 end
        '{0,0,0,0,0,12'h000, 2'd0,12'hFFF,1'b0}  // R8 pulse ends
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(string req, logic [1:0] em, logic [11:0] ed, logic eo);
        n_run++;
        if (mode !== em || disp_word !== ed || done !== eo) begin
            n_fail++;
            $display("FAIL %s: actual mode=%0d disp=%h done=%0b expected mode=%0d disp=%h done=%0b",
                     req, mode, disp_word, done, em, ed, eo);
        end
    endtask

    task automatic idle_in();
        rec_btn = 0; stop_btn = 0; play_btn = 0;
        frame_valid = 0; latch_rise = 0; frame_word = 12'h000;
    endtask

    task automatic do_reset();
        idle_in();
        rst_n = 0;
        tick(); tick();
        rst_n = 1;
    endtask

    function automatic logic [11:0] wv(int i);
        return 12'((i * 37 + 5) % 4096);
    endfunction

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        #(20 * 100000);
        n_run++;
        n_fail++;
        $display("FAIL watchdog: actual running expected finished");
        finish_run();
    end

    initial begin
        do_reset();
        tick();
        chk("R1 reset", 2'd0, 12'hFFF, 1'b0);

        for (int i = 0; i < NV; i++) begin
            rec_btn = TBL[i].rec; stop_btn = TBL[i].stop; play_btn = TBL[i].play;
            frame_valid = TBL[i].fv; latch_rise = TBL[i].lat; frame_word = TBL[i].word;
            tick();
            chk($sformatf("table row %0d", i), TBL[i].emode, TBL[i].edisp, TBL[i].edone);
        end

        // R10: hold play through a full replay of 4 frames and beyond
        idle_in();
        play_btn = 1;
        tick();
        chk("R10 start", 2'd2, 12'h111, 1'b0);
        for (int i = 0; i < 4; i++) begin
            latch_rise = 1;
            tick();
        end
        chk("R10 end", 2'd0, 12'hFFF, 1'b1);
        for (int i = 0; i < 3; i++) tick();
        chk("R10 held no restart", 2'd0, 12'hFFF, 1'b0);
        idle_in();
        tick();

        // R12: shorter recording replaces the end mark
        rec_btn = 1; tick(); rec_btn = 0;
        frame_valid = 1; frame_word = 12'hABC; tick();
        frame_word = 12'hDEF; tick();
        frame_valid = 0; stop_btn = 1; tick();
        chk("R12 stop", 2'd0, 12'hFFF, 1'b1);
        idle_in(); play_btn = 1; tick(); play_btn = 0;
        chk("R12 first", 2'd2, 12'hABC, 1'b0);
        latch_rise = 1; tick();
        chk("R12 second", 2'd2, 12'hDEF, 1'b0);
        tick();
        chk("R12 short end", 2'd0, 12'hFFF, 1'b1);
        idle_in();

        // R11: play with nothing recorded
        do_reset();
        play_btn = 1; tick();
        chk("R11 empty play", 2'd0, 12'hFFF, 1'b1);
        tick();
        chk("R11 pulse ends", 2'd0, 12'hFFF, 1'b0);
        idle_in(); tick();

        // R6: capacity end after 300 frames
        rec_btn = 1; tick(); rec_btn = 0;
        for (int i = 0; i < 300; i++) begin
            frame_valid = 1; frame_word = wv(i);
            tick();
            if (i == 298) chk("R6 before cap", 2'd1, wv(i), 1'b0);
        end
        chk("R6 cap end", 2'd0, 12'hFFF, 1'b1);
        idle_in(); tick();
        play_btn = 1; tick(); play_btn = 0;
        chk("R6 replay first", 2'd2, wv(0), 1'b0);
        for (int i = 1; i < 300; i++) begin
            latch_rise = 1;
            tick();
        end
        chk("R6 last frame kept", 2'd2, wv(299), 1'b0);
        tick();
        chk("R8 cap replay end", 2'd0, 12'hFFF, 1'b1);
        idle_in(); tick();

        finish_run();
    end
endmodule